// File: doc/BRIEF.md
# SPI Frame CRC Generator and Checker

This block sits beside an SPI shift engine and protects a transfer with a cyclic redundancy check. It keeps two running CRC registers: one over every frame the shifter sends and one over every frame it receives. Both use a polynomial that software programs. Frames are 8 or 16 bits wide, and the CRC width always matches the frame width. Each completed frame updates its CRC in a single clock.

Software closes a transfer by arming the unit. It can write the next-is-CRC control bit, or a DMA controller can pulse its count-done input when the last counted frame has been handed over. The data frame that completes in the arming cycle, or the first one after it, is the last data frame. The transmit state machine then presents the transmit CRC to the shifter as one extra frame. The receive state machine treats the frame after the last data frame as the peer's CRC and compares it with the local receive CRC. A mismatch sets a sticky error flag, which can drive the interrupt line. Every received frame goes to the data register, including the CRC frame. Each one sets the buffer-full flag, which also drives the DMA read request when receive DMA is on.

Transmit states: TX_RUN (normal data), TX_LAST (armed, waiting for the last data frame), TX_SEND (CRC frame offered to the shifter).
Transmit transitions:
- TX_RUN goes to TX_LAST on arm.
- TX_RUN goes straight to TX_SEND on arm together with a frame done.
- TX_LAST goes to TX_SEND on a frame done.
- TX_SEND goes back to TX_RUN on a frame done.

Receive states: RX_RUN, RX_LAST, RX_CHK, with the same transitions. In RX_CHK the incoming frame is compared rather than accumulated. When the enable bit is low, both machines are forced back to their RUN state.

Top module: `spi_crc_unit`

## Requirements
- R1: After reset the registers read as follows: polynomial (address 1) = 0x0007; CTRL (address 0), TX CRC (address 2), RX CRC (address 3) and STAT (address 4) = 0. The tx_crc_req, dma_rd_req and irq outputs are low.
- R2: A write to CTRL that takes bit 0 (enable) from 0 to 1 clears both CRC registers. While enable is 0, frames leave both CRC registers unchanged, and arming requests are ignored.
- R3: A CRC register updates on each data frame done: TX CRC on tx_done with tx_word, RX CRC on rx_done with rx_word. The update is an MSB-first division with an implicit top polynomial bit, no reflection and no final XOR. When CTRL bit 3 is 0 the width is 8 bits, using only the low byte of the frame and of the polynomial; when bit 3 is 1 it is 16 bits.
- R4: Arming happens on a CTRL write with bit 1 set, or on a dma_count_done pulse, only while enable is 1. The frame that completes in the arming cycle, or else the next one to complete, is the last data frame.
- R5: After the last transmit data frame, tx_crc_req stays high and tx_crc_word holds the TX CRC until the next tx_done. That CRC frame does not change the TX CRC.
- R6: The received frame after the last receive data frame is compared with the RX CRC. A mismatch sets STAT bit 0. That frame does not change the RX CRC.
- R7: irq equals STAT bit 0 AND CTRL bit 2.
- R8: Writing 0 to STAT bit 0 clears it, and writing 1 has no effect. A mismatch detected in the same cycle as the clearing write leaves the flag set.
- R9: Every received frame, masked to the frame width, is stored and read back at address 5. It sets STAT bit 1. A read of address 5 with reg_rd clears STAT bit 1, unless a frame arrives in that same cycle. dma_rd_req equals STAT bit 1 AND CTRL bit 4.
- R10: CTRL bit 1 reads 1 from arming until both the transmit CRC frame has been sent and the receive CRC frame has been taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| tx_done | input | 1 | Shifter finished sending a frame |
| tx_word | input | DATA_W | Frame that was just sent |
| rx_done | input | 1 | Shifter finished receiving a frame |
| rx_word | input | DATA_W | Frame that was just received |
| dma_count_done | input | 1 | DMA delivered its last counted frame |
| tx_crc_req | output | 1 | Next frame to send is the CRC |
| tx_crc_word | output | DATA_W | CRC frame to send |
| dma_rd_req | output | 1 | Receive DMA request |
| irq | output | 1 | Error interrupt |

## Verification
Two functions can land in the same clock edge. The first pair is the mismatch detection on the received CRC frame and a software write of zero to the error flag; the bench drives both strobes at one edge and expects the flag to stay set. The second pair is the data-register read that clears buffer-full and the arrival of a new received frame; the bench expects the flag to stay set and the new frame to be stored. A third case drives arming together with a frame done, and the bench expects that frame to become the last data frame, so the CRC request rises on the very next cycle.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    typedef enum logic [1:0] {
        TX_RUN  = 2'd0,
        TX_LAST = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_RUN  = 2'd0,
        RX_LAST = 2'd1,
        RX_CHK  = 2'd2
    } rx_state_e;

    // register addresses
    localparam int A_CTRL  = 0;
    localparam int A_POLY  = 1;
    localparam int A_TXCRC = 2;
    localparam int A_RXCRC = 3;
    localparam int A_STAT  = 4;
    localparam int A_DATA  = 5;

    // control bits
    localparam int CB_EN   = 0;
    localparam int CB_ARM  = 1;
    localparam int CB_IE   = 2;
    localparam int CB_WIDE = 3;
    localparam int CB_RDMA = 4;

    // status bits
    localparam int SB_ERR  = 0;
    localparam int SB_FULL = 1;

endpackage

// File: rtl/spi_crc_engine.sv
module spi_crc_engine #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         upd,
    input  logic         wide,
    input  logic [W-1:0] din,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] LO_MASK = {{(W-HALF){1'b0}}, {HALF{1'b1}}};

    function automatic logic [W-1:0] crc_step(
        input logic [W-1:0] cur,
        input logic [W-1:0] d,
        input logic [W-1:0] p,
        input logic         wd
    );
        logic [W-1:0] c;
        logic         fb;
        int           top;
        c   = cur;
        top = wd ? W - 1 : HALF - 1;
        for (int i = W - 1; i >= 0; i--) begin
            if (wd || i < HALF) begin
                fb = c[top] ^ d[i];
                c  = c << 1;
                if (!wd) c = c & LO_MASK;
                if (fb) c = c ^ (wd ? p : (p & LO_MASK));
            end
        end
        return c;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= '0;
        else if (clear) crc <= '0;
        else if (upd)   crc <= crc_step(crc, din, poly, wide);
    end

    // R3
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clear) |=> $stable(crc));

endmodule

// File: rtl/spi_crc_txfsm.sv
module spi_crc_txfsm import spi_crc_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         arm,
    input  logic         frame_done,
    input  logic [W-1:0] crc,
    output logic         upd,
    output logic         crc_req,
    output logic [W-1:0] crc_word,
    output logic         busy
);
    tx_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_RUN:  if (arm) st_nx = frame_done ? TX_SEND : TX_LAST;
            TX_LAST: if (frame_done) st_nx = TX_SEND;
            TX_SEND: if (frame_done) st_nx = TX_RUN;
            default: st_nx = TX_RUN;
        endcase
        if (!en) st_nx = TX_RUN;
    end

    always_comb begin
        upd      = en && frame_done && (st != TX_SEND);
        crc_req  = (st == TX_SEND);
        crc_word = crc;
        busy     = (st != TX_RUN);
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_req && !frame_done && en) |=> crc_req);

    // R5
    word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_req && !frame_done && en) |=> $stable(crc_word));

    // R4
    req_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_req) |-> $past(frame_done));

endmodule

// File: rtl/spi_crc_rxfsm.sv
module spi_crc_rxfsm import spi_crc_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         arm,
    input  logic         frame_done,
    input  logic [W-1:0] frame,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] crc,
    output logic         upd,
    output logic         err_set,
    output logic         busy
);
    rx_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_RUN:  if (arm) st_nx = frame_done ? RX_CHK : RX_LAST;
            RX_LAST: if (frame_done) st_nx = RX_CHK;
            RX_CHK:  if (frame_done) st_nx = RX_RUN;
            default: st_nx = RX_RUN;
        endcase
        if (!en) st_nx = RX_RUN;
    end

    always_comb begin
        upd     = en && frame_done && (st != RX_CHK);
        err_set = en && frame_done && (st == RX_CHK) && ((frame & mask) != crc);
        busy    = (st != RX_RUN);
    end

    // R6
    chk_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_CHK && frame_done) |=> (st == RX_RUN));

endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit import spi_crc_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_done,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              dma_count_done,
    output logic              tx_crc_req,
    output logic [DATA_W-1:0] tx_crc_word,
    output logic              dma_rd_req,
    output logic              irq
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_MASK  = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] POLY_RST = DATA_W'(7);

    logic              en_q, ie_q, wide_q, rdma_q;
    logic              err_q, full_q;
    logic [DATA_W-1:0] poly_q, data_q;
    logic [DATA_W-1:0] tx_crc, rx_crc, frame_mask;
    logic              tx_upd, rx_upd, err_set, tx_busy, rx_busy;
    logic              wr_ctrl, wr_poly, wr_stat, rd_data;
    logic              en_rise, arm;

    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_poly    = reg_wr && (reg_addr == ADDR_W'(A_POLY));
    assign wr_stat    = reg_wr && (reg_addr == ADDR_W'(A_STAT));
    assign rd_data    = reg_rd && (reg_addr == ADDR_W'(A_DATA));
    assign en_rise    = wr_ctrl && reg_wdata[CB_EN] && !en_q;
    assign arm        = en_q && ((wr_ctrl && reg_wdata[CB_ARM]) || dma_count_done);
    assign frame_mask = wide_q ? '1 : LO_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            wide_q <= 1'b0;
            rdma_q <= 1'b0;
            poly_q <= POLY_RST;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[CB_EN];
                ie_q   <= reg_wdata[CB_IE];
                wide_q <= reg_wdata[CB_WIDE];
                rdma_q <= reg_wdata[CB_RDMA];
            end
            if (wr_poly) poly_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (err_set)                            err_q <= 1'b1;
            else if (wr_stat && !reg_wdata[SB_ERR]) err_q <= 1'b0;
            if (rx_done) begin
                full_q <= 1'b1;
                data_q <= rx_word & frame_mask;
            end else if (rd_data) begin
                full_q <= 1'b0;
            end
        end
    end

    spi_crc_engine #(.W(DATA_W)) u_tx_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (en_rise),
        .upd   (tx_upd),
        .wide  (wide_q),
        .din   (tx_word),
        .poly  (poly_q),
        .crc   (tx_crc)
    );

    spi_crc_engine #(.W(DATA_W)) u_rx_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (en_rise),
        .upd   (rx_upd),
        .wide  (wide_q),
        .din   (rx_word),
        .poly  (poly_q),
        .crc   (rx_crc)
    );

    spi_crc_txfsm #(.W(DATA_W)) u_tx_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .arm        (arm),
        .frame_done (tx_done),
        .crc        (tx_crc),
        .upd        (tx_upd),
        .crc_req    (tx_crc_req),
        .crc_word   (tx_crc_word),
        .busy       (tx_busy)
    );

    spi_crc_rxfsm #(.W(DATA_W)) u_rx_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .arm        (arm),
        .frame_done (rx_done),
        .frame      (rx_word),
        .mask       (frame_mask),
        .crc        (rx_crc),
        .upd        (rx_upd),
        .err_set    (err_set),
        .busy       (rx_busy)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CTRL): begin
                reg_rdata[CB_EN]   = en_q;
                reg_rdata[CB_ARM]  = tx_busy || rx_busy;
                reg_rdata[CB_IE]   = ie_q;
                reg_rdata[CB_WIDE] = wide_q;
                reg_rdata[CB_RDMA] = rdma_q;
            end
            ADDR_W'(A_POLY):  reg_rdata = poly_q;
            ADDR_W'(A_TXCRC): reg_rdata = tx_crc;
            ADDR_W'(A_RXCRC): reg_rdata = rx_crc;
            ADDR_W'(A_STAT): begin
                reg_rdata[SB_ERR]  = err_q;
                reg_rdata[SB_FULL] = full_q;
            end
            ADDR_W'(A_DATA):  reg_rdata = data_q;
            default:          reg_rdata = '0;
        endcase
    end

    assign irq        = err_q && ie_q;
    assign dma_rd_req = full_q && rdma_q;

    // R6
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(rx_done));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_stat && !reg_wdata[SB_ERR])) |=> err_q);

    // R9
    full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(rx_done));

    // R2
    arm_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !tx_busy) |=> !tx_crc_req);

endmodule

// File: tb/spi_crc_unit_test.sv
module spi_crc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_done = 1'b0, rx_done = 1'b0, dma_count_done = 1'b0;
    logic [15:0] tx_word = '0, rx_word = '0;
    logic        tx_crc_req, dma_rd_req, irq;
    logic [15:0] tx_crc_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_crc_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done(tx_done), .tx_word(tx_word),
        .rx_done(rx_done), .rx_word(rx_word), .dma_count_done(dma_count_done),
        .tx_crc_req(tx_crc_req), .tx_crc_word(tx_crc_word), .dma_rd_req(dma_rd_req), .irq(irq)
    );

    // remainder of ((c^d) * x^n) modulo the polynomial with its top bit restored
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d,
                                            input logic [15:0] p, input bit w16);
        int          n;
        logic [15:0] m;
        logic [31:0] v;
        logic [31:0] g;
        n = w16 ? 16 : 8;
        m = w16 ? 16'hFFFF : 16'h00FF;
        v = {16'h0, (c ^ d) & m} << n;
        g = (32'h1 << n) | {16'h0, p & m};
        for (int i = 2 * n - 1; i >= n; i--)
            if (v[i]) v = v ^ (g << (i - n));
        return v[15:0] & m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 v = reg_rdata;
    endtask

    task automatic frames(input bit t, input logic [15:0] dt, input bit r, input logic [15:0] dr);
        @(negedge clk);
        tx_done = t; tx_word = dt; rx_done = r; rx_word = dr;
        @(negedge clk);
        tx_done = 1'b0; rx_done = 1'b0;
    endtask

    logic [15:0] v, et, er, lf, pl;
    logic [15:0] polys8 [4] = '{16'h07, 16'h1D, 16'h31, 16'h9B};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1, v); chk("R1 poly", v, 16'h0007);
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(2, v); chk("R1 txcrc", v, 0);
        rd(3, v); chk("R1 rxcrc", v, 0);
        rd(4, v); chk("R1 stat", v, 0);
        chk("R1 outs", {tx_crc_req, dma_rd_req, irq}, 0);

        // R3 exhaustive 8-bit single-frame sweep over four polynomials
        foreach (polys8[k]) begin
            wr(1, polys8[k]);
            for (int d = 0; d < 256; d++) begin
                wr(0, 16'h0000);
                wr(0, 16'h0001);
                frames(1, 16'(d), 1, 16'(d) ^ 16'h5A);
                rd(2, v); chk("R3 tx8", v, ref_crc(16'h0, 16'(d), polys8[k], 1'b0));
                rd(3, v); chk("R3 rx8", v, ref_crc(16'h0, 16'(d) ^ 16'h5A, polys8[k], 1'b0));
            end
        end

        // R3 16-bit chained frames, two polynomials
        for (int q = 0; q < 2; q++) begin
            pl = (q == 0) ? 16'h8005 : 16'h1021;
            wr(1, pl); wr(0, 16'h0000); wr(0, 16'h0009);
            et = 0; er = 0; lf = 16'hACE1;
            for (int k = 0; k < 64; k++) begin
                frames(1, lf, 1, ~lf);
                et = ref_crc(et, lf, pl, 1'b1);
                er = ref_crc(er, ~lf, pl, 1'b1);
                rd(2, v); chk("R3 tx16", v, et);
                rd(3, v); chk("R3 rx16", v, er);
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            end
        end

        // R4/R5/R6/R10 CPU arming, 16-bit loopback, matching CRC
        wr(1, 16'h1021); wr(0, 16'h0000); wr(0, 16'h0009);
        et = 0;
        for (int k = 0; k < 3; k++) begin
            frames(1, 16'h1111 * 16'(k + 1), 1, 16'h1111 * 16'(k + 1));
            et = ref_crc(et, 16'h1111 * 16'(k + 1), 16'h1021, 1'b1);
        end
        wr(0, 16'h000B);
        rd(0, v); chk("R10 armed", v[1], 1);
        chk("R4 no req before last", tx_crc_req, 0);
        frames(1, 16'hBEEF, 1, 16'hBEEF);
        et = ref_crc(et, 16'hBEEF, 16'h1021, 1'b1);
        #1 chk("R5 req", tx_crc_req, 1);
        chk("R5 word", tx_crc_word, et);
        frames(1, et, 0, 16'h0);
        #1 chk("R5 req drop", tx_crc_req, 0);
        rd(2, v); chk("R5 txcrc kept", v, et);
        rd(0, v); chk("R10 rx pending", v[1], 1);
        frames(0, 16'h0, 1, et);
        rd(4, v); chk("R6 no err", v[0], 0);
        rd(3, v); chk("R6 rxcrc kept", v, et);
        rd(0, v); chk("R10 done", v[1], 0);
        rd(5, v); chk("R9 crc in data", v, et);
        rd(4, v); chk("R9 full", v[1], 1);

        // R4/R6/R7/R8 DMA arming, 8-bit, mismatch
        wr(1, 16'h0007); wr(0, 16'h0000); wr(0, 16'h0005);
        et = 0;
        for (int k = 0; k < 3; k++) begin
            frames(1, 16'h12 + 16'(k) * 16'h22, 1, 16'h12 + 16'(k) * 16'h22);
            et = ref_crc(et, 16'h12 + 16'(k) * 16'h22, 16'h7, 1'b0);
        end
        @(negedge clk); dma_count_done = 1'b1;
        @(negedge clk); dma_count_done = 1'b0;
        frames(1, 16'h78, 1, 16'h78);
        et = ref_crc(et, 16'h78, 16'h7, 1'b0);
        #1 chk("R4 dma req", tx_crc_req, 1);
        chk("R4 dma word", tx_crc_word, et);
        frames(1, et, 1, et ^ 16'h1);
        rd(4, v); chk("R6 mismatch", v[0], 1);
        chk("R7 irq on", irq, 1);
        wr(0, 16'h0001);
        #1 chk("R7 irq masked", irq, 0);
        wr(4, 16'h0001);
        rd(4, v); chk("R8 write one", v[0], 1);
        wr(4, 16'h0000);
        rd(4, v); chk("R8 clear", v[0], 0);

        // R4 arm in the same cycle as a frame done; R8 set beats clear
        frames(1, 16'hA1, 1, 16'hA1);
        frames(1, 16'hB2, 1, 16'hB2);
        et = ref_crc(ref_crc(et, 16'hA1, 16'h7, 1'b0), 16'hB2, 16'h7, 1'b0);
        @(negedge clk);
        dma_count_done = 1'b1; tx_done = 1'b1; tx_word = 16'hC3; rx_done = 1'b1; rx_word = 16'hC3;
        @(negedge clk);
        dma_count_done = 1'b0; tx_done = 1'b0; rx_done = 1'b0;
        et = ref_crc(et, 16'hC3, 16'h7, 1'b0);
        #1 chk("R4 coincident req", tx_crc_req, 1);
        chk("R4 coincident word", tx_crc_word, et);
        frames(1, et, 0, 16'h0);
        @(negedge clk);
        rx_done = 1'b1; rx_word = et ^ 16'h80;
        reg_addr = 3'd4; reg_wdata = 16'h0; reg_wr = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; reg_wr = 1'b0;
        rd(4, v); chk("R8 set wins", v[0], 1);
        wr(4, 16'h0000);
        rd(4, v); chk("R8 clear after", v[0], 0);

        // R2 disabled: no update, arm ignored, enable clears
        wr(0, 16'h0000);
        frames(1, 16'h55, 1, 16'h66);
        rd(2, v); chk("R2 tx hold", v, et);
        rd(3, v); chk("R2 rx hold", v, et);
        wr(0, 16'h0002);
        rd(0, v); chk("R2 arm ignored", v[1], 0);
        frames(1, 16'h55, 0, 16'h0);
        #1 chk("R2 no req", tx_crc_req, 0);
        wr(0, 16'h0001);
        rd(2, v); chk("R2 tx cleared", v, 0);
        rd(3, v); chk("R2 rx cleared", v, 0);

        // R9 data register, DMA request, read/arrive collision, 8-bit mask
        wr(0, 16'h0011);
        frames(0, 16'h0, 1, 16'hAB3C);
        #1 chk("R9 dma req", dma_rd_req, 1);
        @(negedge clk);
        reg_addr = 3'd5; reg_rd = 1'b1;
        #1 chk("R9 masked data", reg_rdata, 16'h003C);
        @(negedge clk);
        reg_rd = 1'b0;
        #1 chk("R9 req cleared", dma_rd_req, 0);
        rd(4, v); chk("R9 full cleared", v[1], 0);
        frames(0, 16'h0, 1, 16'h44);
        @(negedge clk);
        reg_addr = 3'd5; reg_rd = 1'b1; rx_done = 1'b1; rx_word = 16'h99;
        @(negedge clk);
        reg_rd = 1'b0; rx_done = 1'b0;
        rd(4, v); chk("R9 arrive wins", v[1], 1);
        rd(5, v); chk("R9 new data", v, 16'h99);
        wr(0, 16'h0001);
        #1 chk("R9 rdma off", dma_rd_req, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule